// File: doc/BRIEF.md
# Grouped Interrupt Expander

This block collects a wide field of peripheral interrupt requests and folds them onto a small set of CPU interrupt lines. The sources are split into groups of eight. Each group drives one CPU line. Every source has a pending flag that latches its request and an enable bit that software controls. Within a group, a fixed hardware priority picks the winner. When the CPU acknowledges a group, the block clears the flag of the winning source. One cycle later it presents that source's number and its vector word, so the CPU never has to search for the handler in software.

The vector words sit in a writable table with one entry per source. A simple address/data register port gives software access to the vector table, the enable byte of each group and the flag byte of each group. The default build has 12 groups of 8 sources, which gives 96 sources, and each vector word is 22 bits wide.

Top module: `irq_group_expander`

## Requirements
- R1: After a synchronous reset, all flags, enables and vector entries are zero, `cpu_int` is zero, `vec_valid` is 0, and `vec_src`, `vec_data` and `reg_rdata` are zero.
- R2: When `irq_in[i]` is high at a clock edge, the flag of source i is set at that edge whatever its enable is. A flag is cleared only by an acknowledge that selects it or by a flag-byte write.
- R3: `cpu_int[g]` is high exactly when some source g*8+b (b = 0..7) has both its flag and its enable set. A request that arrives at edge t shows up on the line right after edge t.
- R4: Within a group, the lowest-numbered source that is pending and enabled is the winner.
- R5: An acknowledge is `ack_valid` = 1 with `ack_group` = g. If g < 12 and group g has a winner, then after that edge `vec_valid` is 1, `vec_src` holds the winner's number and `vec_data` holds its vector entry as stored before that edge, and the winner's flag is cleared. If g ≥ 12 or the group has no winner, `vec_valid` is 0, no state changes, and `vec_src`/`vec_data` keep their last values.
- R6: Register map on the 8-bit `reg_addr`:
  - 0x00–0x5F selects vector entry i = address.
  - 0x80+g (g < 12) selects the enable byte of group g, with bit b belonging to source g*8+b.
  - 0xA0+g (g < 12) selects the flag byte of group g, laid out the same way.
  - For the byte registers, the upper read bits are 0.
  - Every other address reads 0, and writes to it are ignored.
- R7: A read is `reg_en` = 1 with `reg_we` = 0. It puts the addressed value, as it was before the edge, onto `reg_rdata` after the edge. `reg_rdata` holds its value in every other cycle.
- R8: A flag-byte write replaces the group's flags with `reg_wdata[7:0]`. After that, an acknowledge clear is applied in the same cycle. A request arriving in the same cycle then sets its flag, so a request beats a write of 0.
- R9: An enable-byte write takes effect at its edge. A flag latched while its enable was low raises the group line once the enable is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 96 | Peripheral request per source |
| cpu_int | output | 12 | One interrupt line per group |
| ack_valid | input | 1 | CPU acknowledge strobe |
| ack_group | input | 4 | Group being acknowledged |
| vec_valid | output | 1 | Vector presented this cycle |
| vec_src | output | 7 | Number of the acknowledged source |
| vec_data | output | 22 | Vector word of the acknowledged source |
| reg_en | input | 1 | Register access strobe |
| reg_we | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 22 | Register write data |
| reg_rdata | output | 22 | Register read data, one cycle after a read |

## Verification
The bench uses several stimulus patterns, each aimed at a different kind of fault:
- **Single request while disabled, then enabled.** This separates latching a request from forwarding it to the CPU line.
- **Three simultaneous requests in one group, drained by repeated acknowledges.** This exposes a wrong priority order or a wrong flag being cleared.
- **Same-cycle flag write and request.** This distinguishes the update order of the flags.
- **Unmapped addresses and out-of-range groups.** These show up decoding that aliases onto real state.
- **Long random mix.** Sparse requests, acknowledges to every group code and random register traffic are compared against a behavioural model every cycle. This catches interactions between these paths that the directed steps do not reach.

// File: rtl/ige_pkg.sv
`timescale 1ns/1ps
// Shared definitions for the grouped interrupt expander.
// Assumes an 8-bit register address, at most 128 sources and at most 32 groups.
package ige_pkg;

    typedef enum logic [1:0] {
        RGN_VEC,
        RGN_EN,
        RGN_FLAG,
        RGN_NONE
    } region_e;

    localparam logic [2:0] EN_PAGE   = 3'b100;
    localparam logic [2:0] FLAG_PAGE = 3'b101;

    // Classify a register address into the region it selects.
    function automatic region_e decode_region(input logic [7:0] addr,
                                              input int nsrc,
                                              input int ngrp);
        region_e r;
        r = RGN_NONE;
        if (!addr[7]) begin
            if (int'(addr[6:0]) < nsrc) r = RGN_VEC;
        end else if (addr[7:5] == EN_PAGE) begin
            if (int'(addr[4:0]) < ngrp) r = RGN_EN;
        end else if (addr[7:5] == FLAG_PAGE) begin
            if (int'(addr[4:0]) < ngrp) r = RGN_FLAG;
        end
        return r;
    endfunction

endpackage

// File: rtl/ige_group.sv
`timescale 1ns/1ps
// One interrupt group. It holds the pending flags and enables of its sources,
// picks the lowest-numbered pending and enabled source, and drives the
// group's CPU line.
// Assumes: at most one write strobe is active at a time and ack is already
// decoded for this group.
module ige_group #(
    parameter int  GRP_SIZE = 8,
    localparam int IDX_W    = $clog2(GRP_SIZE)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [GRP_SIZE-1:0] req,
    input  logic                en_we,
    input  logic                flag_we,
    input  logic [GRP_SIZE-1:0] wdata,
    input  logic                ack,
    output logic [GRP_SIZE-1:0] flags,
    output logic [GRP_SIZE-1:0] enables,
    output logic                line,
    output logic                win_valid,
    output logic [IDX_W-1:0]    win_idx
);

    logic [GRP_SIZE-1:0] pending;
    logic [GRP_SIZE-1:0] clr_mask;
    logic [GRP_SIZE-1:0] flags_d;

    assign pending = flags & enables;
    assign line    = |pending;

    // Fixed priority: scan from the top down so the lowest set index wins.
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        for (int i = GRP_SIZE - 1; i >= 0; i--) begin
            if (pending[i]) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(i);
            end
        end
    end

    // Next flag value: software overwrite, then ack clear, then new requests.
    always_comb begin
        clr_mask = (ack && win_valid) ? (GRP_SIZE'(1) << win_idx) : '0;
        flags_d  = ((flag_we ? wdata : flags) & ~clr_mask) | req;
    end

    // Flag storage.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= flags_d;
    end

    // Enable storage.
    always_ff @(posedge clk) begin
        if (!rst_n)     enables <= '0;
        else if (en_we) enables <= wdata;
    end

    // R2
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!flag_we && !ack) |=> ((flags & $past(flags)) == $past(flags)));

    // R5
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && win_valid && !flag_we && !req[win_idx]) |=> !flags[$past(win_idx)]);

    // R4
    win_lowest_chk: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> ((pending & ((GRP_SIZE'(1) << win_idx) - GRP_SIZE'(1))) == '0));

    // R9
    en_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en_we |=> $stable(enables));

endmodule

// File: rtl/ige_vector_store.sv
`timescale 1ns/1ps
// Writable vector table with one word per source. It has one write port and
// two asynchronous read ports: one for the acknowledge path and one for the
// register port.
// Assumes the write address has been range-checked by the caller.
module ige_vector_store #(
    parameter int  NSRC  = 96,
    parameter int  VEC_W = 22,
    localparam int SRC_W = $clog2(NSRC)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [SRC_W-1:0] waddr,
    input  logic [VEC_W-1:0] wdata,
    input  logic [SRC_W-1:0] ack_idx,
    output logic [VEC_W-1:0] ack_data,
    input  logic [SRC_W-1:0] reg_idx,
    output logic [VEC_W-1:0] reg_data
);

    logic [VEC_W-1:0] mem [NSRC];

    // Table storage, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NSRC; i++) mem[i] <= '0;
        end else if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // Read ports; an out-of-range index reads zero.
    assign ack_data = (int'(ack_idx) < NSRC) ? mem[ack_idx] : '0;
    assign reg_data = (int'(reg_idx) < NSRC) ? mem[reg_idx] : '0;

    // R6
    vec_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/irq_group_expander.sv
`timescale 1ns/1ps
// Grouped interrupt expander top. It folds N_GROUPS*GRP_SIZE request inputs
// onto N_GROUPS CPU lines. On an acknowledge it returns the winning source
// and its vector word one cycle later. A register port exposes the vectors,
// enables and flags.
// Assumes GRP_SIZE <= VEC_W, at most 128 sources and at most 32 groups.
module irq_group_expander
    import ige_pkg::*;
#(
    parameter int  N_GROUPS = 12,
    parameter int  GRP_SIZE = 8,
    parameter int  VEC_W    = 22,
    localparam int NSRC     = N_GROUPS * GRP_SIZE,
    localparam int SRC_W    = $clog2(NSRC),
    localparam int GRP_W    = $clog2(N_GROUPS),
    localparam int IDX_W    = $clog2(GRP_SIZE)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NSRC-1:0]     irq_in,
    output logic [N_GROUPS-1:0] cpu_int,
    input  logic                ack_valid,
    input  logic [GRP_W-1:0]    ack_group,
    output logic                vec_valid,
    output logic [SRC_W-1:0]    vec_src,
    output logic [VEC_W-1:0]    vec_data,
    input  logic                reg_en,
    input  logic                reg_we,
    input  logic [7:0]          reg_addr,
    input  logic [VEC_W-1:0]    reg_wdata,
    output logic [VEC_W-1:0]    reg_rdata
);

    region_e             rgn;
    logic [4:0]          page_grp;
    logic                wr_stb;
    logic                rd_stb;
    logic [GRP_SIZE-1:0] grp_flags [N_GROUPS];
    logic [GRP_SIZE-1:0] grp_en    [N_GROUPS];
    logic [N_GROUPS-1:0] grp_win_valid;
    logic [IDX_W-1:0]    grp_win_idx [N_GROUPS];
    logic                sel_hit;
    logic [SRC_W-1:0]    sel_src;
    logic [VEC_W-1:0]    ack_vec_data;
    logic [VEC_W-1:0]    reg_vec_data;
    logic [VEC_W-1:0]    rd_value;

    assign rgn      = decode_region(reg_addr, NSRC, N_GROUPS);
    assign page_grp = reg_addr[4:0];
    assign wr_stb   = reg_en && reg_we;
    assign rd_stb   = reg_en && !reg_we;

    // One flag/enable/priority slice per group.
    for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
        ige_group #(
            .GRP_SIZE(GRP_SIZE)
        ) u_grp (
            .clk      (clk),
            .rst_n    (rst_n),
            .req      (irq_in[g*GRP_SIZE +: GRP_SIZE]),
            .en_we    (wr_stb && (rgn == RGN_EN) && (page_grp == 5'(g))),
            .flag_we  (wr_stb && (rgn == RGN_FLAG) && (page_grp == 5'(g))),
            .wdata    (reg_wdata[GRP_SIZE-1:0]),
            .ack      (ack_valid && (ack_group == GRP_W'(g))),
            .flags    (grp_flags[g]),
            .enables  (grp_en[g]),
            .line     (cpu_int[g]),
            .win_valid(grp_win_valid[g]),
            .win_idx  (grp_win_idx[g])
        );
    end

    // Select the acknowledged group's winner and form its global source number.
    always_comb begin
        sel_hit = 1'b0;
        sel_src = '0;
        for (int g = 0; g < N_GROUPS; g++) begin
            if (ack_valid && (ack_group == GRP_W'(g)) && grp_win_valid[g]) begin
                sel_hit = 1'b1;
                sel_src = SRC_W'(g * GRP_SIZE) + SRC_W'(grp_win_idx[g]);
            end
        end
    end

    ige_vector_store #(
        .NSRC (NSRC),
        .VEC_W(VEC_W)
    ) u_vec (
        .clk     (clk),
        .rst_n   (rst_n),
        .we      (wr_stb && (rgn == RGN_VEC)),
        .waddr   (SRC_W'(reg_addr[6:0])),
        .wdata   (reg_wdata),
        .ack_idx (sel_src),
        .ack_data(ack_vec_data),
        .reg_idx (SRC_W'(reg_addr[6:0])),
        .reg_data(reg_vec_data)
    );

    // Register read multiplexer; unmapped addresses return zero.
    always_comb begin
        rd_value = '0;
        case (rgn)
            RGN_VEC: rd_value = reg_vec_data;
            RGN_EN: begin
                for (int g = 0; g < N_GROUPS; g++)
                    if (page_grp == 5'(g)) rd_value[GRP_SIZE-1:0] = grp_en[g];
            end
            RGN_FLAG: begin
                for (int g = 0; g < N_GROUPS; g++)
                    if (page_grp == 5'(g)) rd_value[GRP_SIZE-1:0] = grp_flags[g];
            end
            default: rd_value = '0;
        endcase
    end

    // Vector presentation register: valid pulses, source and data hold.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_valid <= 1'b0;
            vec_src   <= '0;
            vec_data  <= '0;
        end else begin
            vec_valid <= sel_hit;
            if (sel_hit) begin
                vec_src  <= sel_src;
                vec_data <= ack_vec_data;
            end
        end
    end

    // Register read data, updated only on a read.
    always_ff @(posedge clk) begin
        if (!rst_n)      reg_rdata <= '0;
        else if (rd_stb) reg_rdata <= rd_value;
    end

    // R5
    vec_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> $past(ack_valid));

    // R5
    vec_group_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid |-> ((int'(vec_src) / GRP_SIZE) == int'($past(ack_group))));

    // R7
    rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_stb |=> $stable(reg_rdata));

endmodule

// File: tb/tb_irq_group_expander.sv
`timescale 1ns/1ps
module tb_irq_group_expander;

    localparam int NG = 12;
    localparam int GS = 8;
    localparam int NS = NG * GS;
    localparam int VW = 22;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] irq_in;
    logic [NG-1:0] cpu_int;
    logic          ack_valid;
    logic [3:0]    ack_group;
    logic          vec_valid;
    logic [6:0]    vec_src;
    logic [VW-1:0] vec_data;
    logic          reg_en;
    logic          reg_we;
    logic [7:0]    reg_addr;
    logic [VW-1:0] reg_wdata;
    logic [VW-1:0] reg_rdata;

    always #2 clk = ~clk;

    irq_group_expander dut (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .cpu_int(cpu_int),
        .ack_valid(ack_valid), .ack_group(ack_group),
        .vec_valid(vec_valid), .vec_src(vec_src), .vec_data(vec_data),
        .reg_en(reg_en), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
    );

    int errors = 0;
    int checks = 0;
    bit started = 0;
    bit done = 0;

    // Behavioural reference state
    bit            m_flag [NS];
    bit            m_en   [NS];
    logic [VW-1:0] m_vec  [NS];
    logic          e_vv;
    logic [6:0]    e_src;
    logic [VW-1:0] e_vdata;
    logic [VW-1:0] e_rdata;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic [VW-1:0] vexp(input int i);
        return VW'(32'h2A5000 ^ (i * 1237));
    endfunction

    function automatic logic [VW-1:0] m_read(input logic [7:0] a);
        logic [VW-1:0] r;
        int g;
        r = '0;
        if (a < 8'd96) r = m_vec[a];
        else if (a >= 8'h80 && a < 8'h8C) begin
            g = int'(a) - 'h80;
            for (int b = 0; b < GS; b++) r[b] = m_en[g*GS+b];
        end else if (a >= 8'hA0 && a < 8'hAC) begin
            g = int'(a) - 'hA0;
            for (int b = 0; b < GS; b++) r[b] = m_flag[g*GS+b];
        end
        return r;
    endfunction

    task automatic model_step();
        int win;
        int g;
        win = -1;
        if (ack_valid && ack_group < NG) begin
            for (int b = GS - 1; b >= 0; b--)
                if (m_flag[ack_group*GS+b] && m_en[ack_group*GS+b]) win = ack_group*GS + b;
        end
        e_vv = (win >= 0);
        if (win >= 0) begin
            e_src = 7'(win);
            e_vdata = m_vec[win];
        end
        if (reg_en && !reg_we) e_rdata = m_read(reg_addr);
        if (reg_en && reg_we) begin
            if (reg_addr < 8'd96) m_vec[reg_addr] = reg_wdata;
            else if (reg_addr >= 8'h80 && reg_addr < 8'h8C) begin
                g = int'(reg_addr) - 'h80;
                for (int b = 0; b < GS; b++) m_en[g*GS+b] = reg_wdata[b];
            end else if (reg_addr >= 8'hA0 && reg_addr < 8'hAC) begin
                g = int'(reg_addr) - 'hA0;
                for (int b = 0; b < GS; b++) m_flag[g*GS+b] = reg_wdata[b];
            end
        end
        if (win >= 0) m_flag[win] = 0;
        for (int i = 0; i < NS; i++) if (irq_in[i]) m_flag[i] = 1;
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NS; i++) begin
                m_flag[i] = 0; m_en[i] = 0; m_vec[i] = '0;
            end
            e_vv = 0; e_src = '0; e_vdata = '0; e_rdata = '0;
        end else begin
            model_step();
        end
    end

    task automatic compare();
        logic [NG-1:0] ei;
        for (int g = 0; g < NG; g++) begin
            ei[g] = 0;
            for (int b = 0; b < GS; b++) if (m_flag[g*GS+b] && m_en[g*GS+b]) ei[g] = 1;
        end
        check("R3 group lines vs model", 32'(cpu_int), 32'(ei));
        check("R5 vec_valid vs model", 32'(vec_valid), 32'(e_vv));
        check("R5 vec_src vs model", 32'(vec_src), 32'(e_src));
        check("R5 vec_data vs model", 32'(vec_data), 32'(e_vdata));
        check("R7 reg_rdata vs model", 32'(reg_rdata), 32'(e_rdata));
    endtask

    task automatic idle_inputs();
        irq_in = '0; ack_valid = 0; ack_group = '0;
        reg_en = 0; reg_we = 0; reg_addr = '0; reg_wdata = '0;
    endtask

    task automatic tick();
        @(negedge clk);
        if (started) compare();
    endtask

    task automatic wr(input logic [7:0] a, input logic [VW-1:0] d);
        reg_en = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
        tick(); idle_inputs();
    endtask

    task automatic rd(input logic [7:0] a);
        reg_en = 1; reg_we = 0; reg_addr = a;
        tick(); idle_inputs();
    endtask

    task automatic ack(input logic [3:0] g);
        ack_valid = 1; ack_group = g;
        tick(); idle_inputs();
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        #(4 * 150000);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        idle_inputs();
        rst_n = 0;
        repeat (2) @(negedge clk);
        started = 1;
        tick();
        // R1 reset state
        check("R1 cpu_int after reset", 32'(cpu_int), 0);
        check("R1 vec_valid after reset", 32'(vec_valid), 0);
        check("R1 reg_rdata after reset", 32'(reg_rdata), 0);
        rst_n = 1;
        rd(8'h05);
        check("R1 vector entry cleared", 32'(reg_rdata), 0);

        for (int i = 0; i < NS; i++) wr(8'(i), vexp(i));
        rd(8'd37);
        check("R6 vector readback", 32'(reg_rdata), 32'(vexp(37)));
        tick();
        check("R7 rdata holds when idle", 32'(reg_rdata), 32'(vexp(37)));

        // Latched while disabled, raised when enabled
        irq_in[10] = 1; tick(); idle_inputs();
        check("R9 disabled source keeps line low", 32'(cpu_int[1]), 0);
        rd(8'hA1);
        check("R2 flag latched while disabled", 32'(reg_rdata), 32'h04);
        wr(8'h81, 22'h04);
        check("R9 line rises once enabled", 32'(cpu_int[1]), 1);
        ack(4'd1);
        check("R5 vec_valid on ack", 32'(vec_valid), 1);
        check("R5 vec_src on ack", 32'(vec_src), 10);
        check("R5 vec_data on ack", 32'(vec_data), 32'(vexp(10)));
        check("R5 winner flag cleared", 32'(cpu_int[1]), 0);

        // Priority drain
        wr(8'h82, 22'hFF);
        irq_in[21] = 1; irq_in[19] = 1; irq_in[17] = 1; tick(); idle_inputs();
        ack(4'd2);
        check("R4 first winner", 32'(vec_src), 17);
        ack(4'd2);
        check("R4 second winner", 32'(vec_src), 19);
        ack(4'd2);
        check("R4 third winner", 32'(vec_src), 21);
        ack(4'd2);
        check("R5 empty group gives no vector", 32'(vec_valid), 0);
        check("R5 vec_src holds", 32'(vec_src), 21);

        // Flag write ordering
        wr(8'h83, 22'h83);
        wr(8'hA3, 22'h81);
        check("R8 flag write raises line", 32'(cpu_int[3]), 1);
        rd(8'hA3);
        check("R8 flag write readback", 32'(reg_rdata), 32'h81);
        reg_en = 1; reg_we = 1; reg_addr = 8'hA3; reg_wdata = '0; irq_in[30] = 1;
        tick(); idle_inputs();
        rd(8'hA3);
        check("R8 request beats clearing write", 32'(reg_rdata), 32'h40);
        check("R3 disabled pending keeps line low", 32'(cpu_int[3]), 0);

        // Unmapped addresses and groups
        wr(8'h60, 22'h12345);
        rd(8'h60);
        check("R6 unmapped address reads zero", 32'(reg_rdata), 0);
        rd(8'h8C);
        check("R6 enable page beyond groups reads zero", 32'(reg_rdata), 0);
        rd(8'hAC);
        check("R6 flag page beyond groups reads zero", 32'(reg_rdata), 0);
        rd(8'h81);
        check("R6 enable byte upper bits zero", 32'(reg_rdata), 32'h04);
        ack(4'd13);
        check("R5 out-of-range group ignored", 32'(vec_valid), 0);

        // Random mix against the model
        for (int c = 0; c < 4000; c++) begin
            for (int i = 0; i < NS; i++) irq_in[i] = ($urandom_range(0, 99) == 0);
            ack_valid = ($urandom_range(0, 3) == 0);
            ack_group = 4'($urandom_range(0, 15));
            reg_en = ($urandom_range(0, 2) == 0);
            reg_we = 1'($urandom_range(0, 1));
            case ($urandom_range(0, 3))
                0: reg_addr = 8'($urandom_range(0, 127));
                1: reg_addr = 8'h80 + 8'($urandom_range(0, 15));
                2: reg_addr = 8'hA0 + 8'($urandom_range(0, 15));
                default: reg_addr = 8'($urandom_range(0, 255));
            endcase
            reg_wdata = VW'($urandom);
            tick();
        end
        idle_inputs();
        tick();

        done = 1;
        summary();
        $finish;
    end

endmodule